// File: doc/BRIEF.md
# In-Order Integer Pipeline Core

This block is a small in-order integer core with eleven one-cycle stages in a fixed line: fetch, decode, an empty analyze stage, register read, then the add, multiply and divide units, an empty branch stage, two memory stages and writeback. Every instruction passes through every stage. Only the stage that matches its operation changes it. The core reads 32-bit instruction words from a single-port word memory, decodes them, and reads one source from a 128-entry register file of 32-bit registers. It then writes the result back, in program order.

Instructions and load data share the one memory port. While a load sits in either memory stage, fetch holds its program counter and a bubble enters decode. The memory is loaded through a write port while `runEn` is low. Raising `runEn` starts fetch at byte address 0. Fetch stops after it takes the return instruction. `done` rises once the return has retired.

Two counters give the executed cycles and the retired instructions, so their ratio is the instructions per cycle. A read port shows any register at the end of a run.

Top module: `inorder_core`

## Requirements
- R1: Synchronous active-high `rst` clears every register, the program counter, the pipeline, `done` and both counters to zero.
- R2: Instruction word layout: bits 31:24 hold the opcode byte, bits 23:16 the destination (bit 23 ignored), bits 15:8 the left operand and bits 7:0 the right operand. Opcode bit 7 selects the register form. Opcode bits 2:0 give the operation: set=0, add=1, sub=2, mul=3, div=4, ld=5, ret=6. set takes bits 15:0 as a 16-bit immediate and ignores the register flag.
- R3: set writes its zero-extended immediate. add and sub write left plus or minus right, modulo 2^32.
- R4: mul writes the low 32 bits of left times right.
- R5: div writes the unsigned quotient with the fraction discarded. A zero divisor writes 0.
- R6: In the register form, the left operand is the register selected by bits 14:8 (bit 15 ignored). The right operand is always an unsigned 8-bit immediate.
- R7: ld writes the memory word at byte address / 4. The address comes from bits 15:0 in the immediate form, or from the register selected by bits 14:8 in the register form.
- R8: Fetch is held for every cycle that a load occupies a memory stage. Take a program of N instructions up to and including ret, with L loads. If the loads are at least two apart and each has at least eight instructions after it before ret, `done` rises at the N+10+2L-th rising edge after `runEn` goes high.
- R9: After ret is fetched, no later instruction is fetched or executed. `done` rises after ret leaves writeback and stays high until reset.
- R10: `cycleCount` counts cycles with `runEn` high and `done` low, and then freezes. `retireCount` counts instructions that leave writeback, ret included and bubbles excluded.
- R11: An opcode with bits 6:3 non-zero, or with operation code 7, writes no register but still retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| runEn | input | 1 | High: core runs; low: memory write port is enabled |
| initWe | input | 1 | Memory word write strobe, honoured while runEn is low |
| initAddr | input | $clog2(MEM_WORDS) | Memory word index for preload |
| initData | input | 32 | Memory word to write |
| peekIdx | input | 7 | Register to show on peekData |
| peekData | output | 32 | Current value of register peekIdx |
| done | output | 1 | Return instruction has retired |
| cycleCount | output | CNT_W | Executed cycles |
| retireCount | output | CNT_W | Retired instructions |

## Verification
The assertions and the expected values rely on several conditions on the inputs:
- `runEn` stays high from the first fetch until `done`.
- No instruction reads a register written by any of the eight instructions before it, because the core has no dependency check.
- Loads touch only words that were preloaded.

The programs in the stimulus keep to these conditions. They place sources far ahead of their consumers or pad with no-op words, and they space loads as R8 describes. Results are compared against a model of the instruction semantics that the bench steps through as it builds each program.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 128;
  localparam int RIDX_W = $clog2(NREG);
  localparam int BYTE_W = 8;
  localparam int IMM_W  = 2 * BYTE_W;

  localparam int STG_IA  = 1;
  localparam int STG_RR  = 2;
  localparam int STG_ADD = 3;
  localparam int STG_MUL = 4;
  localparam int STG_DIV = 5;
  localparam int STG_BR  = 6;
  localparam int STG_M1  = 7;
  localparam int STG_M2  = 8;
  localparam int STG_WB  = 9;

  typedef enum logic [2:0] {
    OP_SET = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MUL = 3'd3,
    OP_DIV = 3'd4, OP_LD  = 3'd5, OP_RET = 3'd6, OP_NOP = 3'd7
  } opcode_e;

  typedef struct packed {
    logic              valid;
    opcode_e           op;
    logic              useReg;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] srcReg;
    logic [IMM_W-1:0]  immA;
    logic [BYTE_W-1:0] immB;
    logic [XLEN-1:0]   opA;
    logic [XLEN-1:0]   res;
  } slot_t;

  typedef struct packed {
    logic fetchEn;
    logic initAllowed;
  } ctrl_t;

  typedef struct packed {
    logic loadBusy;
    logic fetchIsRet;
    logic wbValid;
    logic wbIsRet;
  } status_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile import core_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] raddrA,
  output logic [XLEN-1:0]   rdataA,
  input  logic [RIDX_W-1:0] raddrB,
  output logic [XLEN-1:0]   rdataB
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdataA = regs[raddrA];
  assign rdataB = regs[raddrB];
endmodule

// File: rtl/core_datapath.sv
module core_datapath import core_pkg::*; #(
  parameter int MEM_WORDS = 1024,
  parameter int AW        = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic              initWe,
  input  logic [AW-1:0]     initAddr,
  input  logic [XLEN-1:0]   initData,
  input  logic [RIDX_W-1:0] peekIdx,
  output logic [XLEN-1:0]   peekData,
  output status_t           status
);
  logic [XLEN-1:0] mem [MEM_WORDS];
  logic [AW+1:0]   pc;
  logic            idValid;
  logic [XLEN-1:0] idWord;
  slot_t           pipe [STG_IA:STG_WB];
  slot_t           nxt  [STG_IA:STG_WB];
  logic            m2Load;
  logic [AW-1:0]   portIdx;
  logic [XLEN-1:0] memRd;
  logic [XLEN-1:0] rfRdA;
  logic            wbWe;
  logic            unusedDstMsb;

  function automatic slot_t decodeWord(logic v, logic [XLEN-1:0] w);
    slot_t s;
    s        = '0;
    s.valid  = v;
    s.useReg = w[31];
    s.dst    = w[22:16];
    s.srcReg = w[14:8];
    s.immB   = w[7:0];
    if (w[30:27] != 4'd0) s.op = OP_NOP;
    else                  s.op = opcode_e'(w[26:24]);
    if (s.op == OP_SET || (s.op == OP_LD && !s.useReg)) s.immA = w[15:0];
    else s.immA = {{BYTE_W{1'b0}}, w[15:8]};
    if (s.op == OP_SET) s.useReg = 1'b0;
    return s;
  endfunction

  function automatic slot_t stageWork(int s, slot_t in, logic [XLEN-1:0] rfRd,
                                      logic [XLEN-1:0] memData);
    slot_t o;
    o = in;
    case (s)
      STG_RR:  o.opA = in.useReg ? rfRd : XLEN'(in.immA);
      STG_ADD: begin
        case (in.op)
          OP_SET:  o.res = in.opA;
          OP_ADD:  o.res = in.opA + XLEN'(in.immB);
          OP_SUB:  o.res = in.opA - XLEN'(in.immB);
          default: o.res = in.res;
        endcase
      end
      STG_MUL: if (in.op == OP_MUL) o.res = in.opA * XLEN'(in.immB);
      STG_DIV: if (in.op == OP_DIV)
                 o.res = (in.immB == '0) ? '0 : in.opA / XLEN'(in.immB);
      STG_M2:  if (in.op == OP_LD) o.res = memData;
      default: o = in;
    endcase
    return o;
  endfunction

  // single shared port: preload, load read, or fetch
  assign m2Load  = pipe[STG_M2].valid && pipe[STG_M2].op == OP_LD;
  assign portIdx = ctrl.initAllowed ? initAddr :
                   m2Load ? pipe[STG_M2].opA[AW+1:2] : pc[AW+1:2];
  assign memRd   = mem[portIdx];

  always_ff @(posedge clk) begin
    if (ctrl.initAllowed && initWe) mem[portIdx] <= initData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      idValid <= 1'b0;
      idWord  <= '0;
    end else begin
      idValid <= ctrl.fetchEn;
      if (ctrl.fetchEn) begin
        idWord <= memRd;
        pc     <= pc + (AW+2)'(4);
      end
    end
  end

  always_comb begin
    nxt[STG_IA] = decodeWord(idValid, idWord);
    for (int k = STG_RR; k <= STG_WB; k++)
      nxt[k] = stageWork(k - 1, pipe[k-1], rfRdA, memRd);
  end

  for (genvar g = STG_IA; g <= STG_WB; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= '0;
      else     pipe[g] <= nxt[g];
    end
  end

  assign wbWe = pipe[STG_WB].valid && pipe[STG_WB].op <= OP_LD;

  core_regfile u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (wbWe),
    .waddr  (pipe[STG_WB].dst),
    .wdata  (pipe[STG_WB].res),
    .raddrA (pipe[STG_RR].srcReg),
    .rdataA (rfRdA),
    .raddrB (peekIdx),
    .rdataB (peekData)
  );

  assign status.loadBusy   = (pipe[STG_M1].valid && pipe[STG_M1].op == OP_LD) || m2Load;
  assign status.fetchIsRet = memRd[30:24] == {4'd0, OP_RET};
  assign status.wbValid    = pipe[STG_WB].valid;
  assign status.wbIsRet    = pipe[STG_WB].valid && pipe[STG_WB].op == OP_RET;
  assign unusedDstMsb      = idWord[23];
endmodule

// File: rtl/core_control.sv
module core_control import core_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             runEn,
  input  status_t          status,
  output ctrl_t            ctrl,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount,
  output logic [CNT_W-1:0] retireCount
);
  logic halted;

  always_comb begin
    ctrl.fetchEn     = runEn && !halted && !done && !status.loadBusy;
    ctrl.initAllowed = !runEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted      <= 1'b0;
      done        <= 1'b0;
      cycleCount  <= '0;
      retireCount <= '0;
    end else begin
      if (ctrl.fetchEn && status.fetchIsRet) halted <= 1'b1;
      if (status.wbIsRet) done <= 1'b1;
      if (runEn && !done) cycleCount <= cycleCount + 1'b1;
      if (status.wbValid && !done) retireCount <= retireCount + 1'b1;
    end
  end
endmodule

// File: rtl/inorder_core.sv
module inorder_core import core_pkg::*; #(
  parameter int MEM_WORDS = 1024,
  parameter int CNT_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         runEn,
  input  logic                         initWe,
  input  logic [$clog2(MEM_WORDS)-1:0] initAddr,
  input  logic [31:0]                  initData,
  input  logic [6:0]                   peekIdx,
  output logic [31:0]                  peekData,
  output logic                         done,
  output logic [CNT_W-1:0]             cycleCount,
  output logic [CNT_W-1:0]             retireCount
);
  localparam int AW = $clog2(MEM_WORDS);

  ctrl_t   ctrl;
  status_t status;

  core_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .runEn       (runEn),
    .status      (status),
    .ctrl        (ctrl),
    .done        (done),
    .cycleCount  (cycleCount),
    .retireCount (retireCount)
  );

  core_datapath #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .initWe   (initWe),
    .initAddr (initAddr),
    .initData (initData),
    .peekIdx  (peekIdx),
    .peekData (peekData),
    .status   (status)
  );
endmodule

// File: rtl/inorder_core_chk.sv
module inorder_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             runEn,
  input logic             done,
  input logic [CNT_W-1:0] cycleCount,
  input logic [CNT_W-1:0] retireCount
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cycleCount == '0 && retireCount == '0 && !done));

  a_r8_cycle_step: assert property (@(posedge clk) disable iff (rst)
    (runEn && !done) |=> cycleCount == CNT_W'($past(cycleCount) + 1'b1));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r10_cycles_frozen: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(cycleCount));

  a_r10_retire_step: assert property (@(posedge clk) disable iff (rst)
    !done |=> (retireCount == $past(retireCount) ||
               retireCount == CNT_W'($past(retireCount) + 1'b1)));

  a_r10_retire_bound: assert property (@(posedge clk) disable iff (rst)
    runEn |-> retireCount <= cycleCount);
endmodule

bind inorder_core inorder_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .runEn       (runEn),
  .done        (done),
  .cycleCount  (cycleCount),
  .retireCount (retireCount)
);

// File: tb/inorder_core_tb.sv
`timescale 1ns/1ps
module inorder_core_tb;
  localparam int MW = 1024;
  localparam int AW = $clog2(MW);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, runEn, initWe, done;
  logic [AW-1:0] initAddr;
  logic [31:0]   initData, peekData, cycleCount, retireCount;
  logic [6:0]    peekIdx;

  inorder_core #(.MEM_WORDS(MW), .CNT_W(32)) u_dut (
    .clk(clk), .rst(rst), .runEn(runEn), .initWe(initWe), .initAddr(initAddr),
    .initData(initData), .peekIdx(peekIdx), .peekData(peekData), .done(done),
    .cycleCount(cycleCount), .retireCount(retireCount)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] progMem [256];
  int          progLen, progN, nLoads;
  bit          retSeen;
  logic [31:0] mdl [128];
  string       tagOf [128];

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dataAt(logic [31:0] addr);
    case ((addr >> 2) % MW)
      250:     return 32'hCAFE0001;
      600:     return 32'h12345678;
      1023:    return 32'hFFFF0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic newProg();
    progLen = 0; progN = 0; nLoads = 0; retSeen = 0;
    for (int r = 0; r < 128; r++) begin mdl[r] = '0; tagOf[r] = "R1"; end
  endtask

  task automatic emit(logic [7:0] ob, logic [7:0] db, logic [7:0] lb, logic [7:0] rb, string tag);
    logic [31:0] left;
    logic [6:0]  d;
    progMem[progLen] = {ob, db, lb, rb};
    progLen++;
    d = db[6:0];
    if (retSeen) begin tagOf[d] = tag; return; end
    progN++;
    left = ob[7] ? mdl[lb[6:0]] : {24'h0, lb};
    if (ob[6:3] != 4'd0 || ob[2:0] == 3'd7) begin
      tagOf[d] = tag;
    end else begin
      case (ob[2:0])
        3'd0: begin mdl[d] = {16'h0, lb, rb}; tagOf[d] = tag; end
        3'd1: begin mdl[d] = left + {24'h0, rb}; tagOf[d] = tag; end
        3'd2: begin mdl[d] = left - {24'h0, rb}; tagOf[d] = tag; end
        3'd3: begin mdl[d] = left * {24'h0, rb}; tagOf[d] = tag; end
        3'd4: begin mdl[d] = (rb == 8'd0) ? 32'h0 : left / {24'h0, rb}; tagOf[d] = tag; end
        3'd5: begin
          mdl[d] = dataAt(ob[7] ? mdl[lb[6:0]] : {16'h0, lb, rb});
          tagOf[d] = tag; nLoads++;
        end
        default: retSeen = 1;
      endcase
    end
  endtask

  task automatic loadWord(int idx, logic [31:0] d);
    initWe = 1'b1; initAddr = AW'(idx); initData = d;
    @(negedge clk);
    initWe = 1'b0;
  endtask

  task automatic runProg(string name);
    int edges;
    bit fin;
    int expCyc;
    logic [31:0] frozen;
    runEn = 1'b0; rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < progLen; i++) loadWord(i, progMem[i]);
    loadWord(250, 32'hCAFE0001);
    loadWord(600, 32'h12345678);
    loadWord(1023, 32'hFFFF0000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1", {name, " done after reset"}, 32'(done), 0);
    check(cycleCount == 0, "R1", {name, " cycleCount after reset"}, cycleCount, 0);
    check(retireCount == 0, "R1", {name, " retireCount after reset"}, retireCount, 0);
    runEn = 1'b1;
    edges = 0; fin = 0;
    while (!fin && edges < 4000) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (done) fin = 1;
    end
    if (!fin) check(0, "R9", {name, " watchdog expired"}, 32'(edges), 0);
    expCyc = progN + 10 + 2 * nLoads;
    check(edges == expCyc, "R8", {name, " edges to done"}, 32'(edges), 32'(expCyc));
    check(cycleCount == 32'(expCyc), "R10", {name, " cycleCount"}, cycleCount, 32'(expCyc));
    check(retireCount == 32'(progN), "R10", {name, " retireCount"}, retireCount, 32'(progN));
    frozen = cycleCount;
    repeat (5) @(negedge clk);
    check(cycleCount == frozen, "R10", {name, " cycleCount frozen"}, cycleCount, frozen);
    check(done == 1'b1, "R9", {name, " done held"}, 32'(done), 1);
    for (int r = 0; r < 128; r++) begin
      peekIdx = 7'(r);
      #1;
      check(peekData == mdl[r], tagOf[r], $sformatf("%s reg %0d", name, r), peekData, mdl[r]);
    end
    runEn = 1'b0;
  endtask

  initial begin
    logic [7:0] av [4];
    logic [7:0] bv [3];
    int idx;
    av[0] = 8'd0; av[1] = 8'd7; av[2] = 8'd200; av[3] = 8'd255;
    bv[0] = 8'd0; bv[1] = 8'd3; bv[2] = 8'd255;
    rst = 1'b1; runEn = 1'b0; initWe = 1'b0; initAddr = '0; initData = '0; peekIdx = '0;
    repeat (3) @(negedge clk);

    // program 1: arithmetic sweep, register forms, no-ops, ret
    newProg();
    emit(8'h00, 8'd60, 8'hBE, 8'hEF, "R3");
    emit(8'h00, 8'd61, 8'h00, 8'h00, "R3");
    emit(8'h00, 8'd62, 8'h9C, 8'h40, "R3");
    idx = 0;
    for (int o = 1; o <= 4; o++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 3; b++) begin
          emit(8'(o), 8'(1 + idx), av[a], bv[b], (o <= 2) ? "R3" : (o == 3) ? "R4" : "R5");
          idx++;
        end
    emit(8'h82, 8'd70, 8'd61, 8'd5, "R6");
    emit(8'h83, 8'd71, 8'd62, 8'd255, "R6");
    emit(8'h81, 8'd72, 8'd60, 8'd1, "R6");
    emit(8'h84, 8'd73, 8'd60, 8'd16, "R5");
    emit(8'h84, 8'd74, 8'd60, 8'd0, "R5");
    for (int j = 0; j < 12; j++)
      emit(8'h80 | 8'((j % 4) + 1), 8'(75 + j), 8'(1 + j * 4), 8'(j * 20 + 1), "R6");
    emit(8'h81, 8'd87, 8'h83, 8'd9, "R6");
    for (int j = 0; j < 8; j++) emit(8'h07, 8'd0, 8'd0, 8'd0, "R11");
    emit(8'h83, 8'd88, 8'd71, 8'd255, "R4");
    for (int j = 0; j < 8; j++) emit(8'h87, 8'd0, 8'd0, 8'd0, "R11");
    emit(8'h83, 8'd89, 8'd88, 8'd255, "R4");
    emit(8'h80, 8'h80 | 8'd90, 8'h12, 8'h34, "R2");
    emit(8'h41, 8'd91, 8'd1, 8'd2, "R11");
    emit(8'h06, 8'd0, 8'd0, 8'd0, "R9");
    emit(8'h00, 8'd100, 8'd0, 8'd77, "R9");
    emit(8'h01, 8'd101, 8'd5, 8'd5, "R9");
    runProg("arith");

    // program 2: loads sharing the port with fetch
    newProg();
    emit(8'h05, 8'd10, 8'h03, 8'hE8, "R7");
    emit(8'h00, 8'd20, 8'h0F, 8'hFC, "R3");
    emit(8'h05, 8'd11, 8'h09, 8'h60, "R7");
    emit(8'h01, 8'd21, 8'd9, 8'd9, "R8");
    for (int j = 0; j < 8; j++) emit(8'h07, 8'd0, 8'd0, 8'd0, "R11");
    emit(8'h85, 8'd12, 8'd20, 8'd0, "R7");
    emit(8'h03, 8'd22, 8'd12, 8'd12, "R8");
    for (int j = 0; j < 8; j++) emit(8'h07, 8'd0, 8'd0, 8'd0, "R11");
    emit(8'h06, 8'd0, 8'd0, 8'd0, "R9");
    runProg("loads");

    // program 3: return only, minimum latency
    newProg();
    emit(8'h06, 8'd0, 8'd0, 8'd0, "R9");
    runProg("ret_only");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule